// File: doc/BRIEF.md
# Host Write Strobe Qualifier with Power-On Hold-Off

This block sits between the host pins of a word-wide nonvolatile memory and its command decoder. It decides whether a write-enable strobe counts as a genuine write cycle. Chip-select, output-enable, write-enable and a digital supply-good flag are brought into the system clock domain through two flip-flops each. A strobe is *qualified* while chip-select is low, output-enable is high and write-enable is low.

A qualified strobe is accepted only if three conditions hold. It must last at least `MIN_WIDTH` clock cycles. Writes must have been enabled on every cycle of the strobe. Writes must still be enabled on the cycle the strobe ends. Writes are enabled only when supply-good is high and a hold-off of `HOLD_CYCLES` cycles has run out. That hold-off restarts whenever supply-good drops.

On each accepted strobe the block pulses `acc_pulse` for one cycle. With the pulse it presents two latched values: the address seen when the strobe began and the data seen when it ended. The command decoder consumes this pulse in place of the raw pin strobe. `holdoff_active` reports when writes are blocked by the supply monitor.

Top module: `wrq_guard`

## Requirements
- R1: Out of reset, `acc_pulse` is 0 and `holdoff_active` is 1.
- R2: A qualified strobe of N cycles produces an accept pulse if N >= `MIN_WIDTH` and none if N < `MIN_WIDTH`. Here N is the number of clock periods that `cs_n`=0, `oe_n`=1 and `we_n`=0 are held at the pins.
- R3: Only the pin combination `cs_n`=0, `oe_n`=1, `we_n`=0 qualifies a strobe. A pulse of any of the other seven combinations, followed by the idle state (all three at 1), produces no accept pulse.
- R4: While `supply_ok` is 0, `holdoff_active` is 1 (from the third clock edge after the pin falls) and no strobe is accepted.
- R5: After `supply_ok` rises, `holdoff_active` stays 1 and is first seen low in the (`HOLD_CYCLES`+2)-th clock period after the pin change. It is 1 in every earlier period, and no write is accepted while it is 1.
- R6: Each fall and return of `supply_ok` restarts the full hold-off of R5.
- R7: `acc_addr` carries the value of `addr_in` sampled when the strobe became qualified. Later changes of `addr_in` during the strobe have no effect.
- R8: `acc_data` carries the value of `data_in` sampled when the strobe ended. Earlier values held during the strobe have no effect.
- R9: An accepted strobe gives exactly one `acc_pulse` cycle. It is visible in the third clock period after the write-enable/chip-select release at the pins.
- R10: `acc_addr` and `acc_data` change only together with an `acc_pulse`. A rejected strobe leaves them unchanged.
- R11: A strobe that begins while `holdoff_active` is 1 is rejected, even if it ends after the hold-off has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip-select, active low |
| oe_n | input | 1 | Host output-enable, active low |
| we_n | input | 1 | Host write-enable, active low |
| supply_ok | input | 1 | Digital supply-good flag, 1 = supply valid |
| addr_in | input | ADDR_W | Host address bus |
| data_in | input | DATA_W | Host data bus |
| acc_pulse | output | 1 | One-cycle pulse for each accepted write |
| acc_addr | output | ADDR_W | Address latched at the start of the accepted strobe |
| acc_data | output | DATA_W | Data latched at the end of the accepted strobe |
| holdoff_active | output | 1 | Writes blocked by supply-low or power-on hold-off |

## Verification
The strobe width is swept from one cycle to a few cycles past `MIN_WIDTH`, which separates rejection at the threshold from acceptance just above it. All eight combinations of the three control pins are each pulsed and then returned to idle, so that the combination rule is told apart from a plain write-enable edge detector. Address and data are changed in the middle of a strobe to show which end of the strobe each one is latched at. The supply flag is held low, raised, and dropped again, so the hold-off length, its restart, and the rejection of a strobe that straddles the end of the hold-off are each observed at the ports.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
    localparam int PIN_CS = 0;
    localparam int PIN_OE = 1;
    localparam int PIN_WE = 2;
    localparam int PIN_PG = 3;
    localparam int NPINS  = 4;
    // idle pin levels: select, output-enable and write-enable high, supply low
    localparam logic [NPINS-1:0] PIN_IDLE = 4'b0111;
endpackage

// File: rtl/wrq_sync.sv
module wrq_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            st_d.s1[i] = din[i];
            st_d.s2[i] = st_q.s1[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/wrq_holdoff.sv
module wrq_holdoff #(
    parameter int HOLD_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_s,
    output logic active,
    output logic wr_en
);
    localparam int HCW = (HOLD_CYCLES < 1) ? 1 : $clog2(HOLD_CYCLES + 1);
    localparam logic [HCW-1:0] HOLD_V = HCW'(HOLD_CYCLES);

    typedef struct packed {
        logic [HCW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!supply_s) begin
            st_d.cnt = HOLD_V;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= HOLD_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.cnt != '0);
    assign wr_en  = supply_s && (st_q.cnt == '0);
endmodule

// File: rtl/wrq_qualify.sv
module wrq_qualify #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int MIN_WIDTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              oe_s,
    input  logic              we_s,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              acc_pulse,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data
);
    localparam int CW = (MIN_WIDTH < 1) ? 1 : $clog2(MIN_WIDTH + 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_WIDTH);

    typedef struct packed {
        logic              prev;
        logic [CW-1:0]     cnt;
        logic              bad;
        logic [ADDR_W-1:0] a_start;
        logic              pulse;
        logic [ADDR_W-1:0] o_addr;
        logic [DATA_W-1:0] o_data;
    } qual_t;

    qual_t st_d, st_q;
    logic  strobe, s_rise, s_fall;

    always_comb begin
        strobe = !cs_s && oe_s && !we_s;
        s_rise = strobe && !st_q.prev;
        s_fall = !strobe && st_q.prev;

        st_d       = st_q;
        st_d.prev  = strobe;
        st_d.pulse = 1'b0;

        if (strobe) begin
            st_d.cnt = (st_q.cnt >= MIN_V) ? st_q.cnt : st_q.cnt + 1'b1;
            st_d.bad = (s_rise ? 1'b0 : st_q.bad) | !wr_en;
            if (s_rise) begin
                st_d.a_start = addr_in;
            end
        end else begin
            st_d.cnt = '0;
            st_d.bad = 1'b0;
        end

        if (s_fall && (st_q.cnt >= MIN_V) && !st_q.bad && wr_en) begin
            st_d.pulse  = 1'b1;
            st_d.o_addr = st_q.a_start;
            st_d.o_data = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_pulse = st_q.pulse;
    assign acc_addr  = st_q.o_addr;
    assign acc_data  = st_q.o_data;
endmodule

// File: rtl/wrq_guard.sv
module wrq_guard #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int MIN_WIDTH   = 3,
    parameter int HOLD_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              supply_ok,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              acc_pulse,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data,
    output logic              holdoff_active
);
    import wrq_pkg::*;

    logic [NPINS-1:0] pins_raw, pins_s;
    logic             wr_en;

    always_comb begin
        pins_raw         = '0;
        pins_raw[PIN_CS] = cs_n;
        pins_raw[PIN_OE] = oe_n;
        pins_raw[PIN_WE] = we_n;
        pins_raw[PIN_PG] = supply_ok;
    end

    wrq_sync #(.W(NPINS), .RST_VAL(PIN_IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    wrq_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .supply_s(pins_s[PIN_PG]),
        .active  (holdoff_active),
        .wr_en   (wr_en)
    );

    wrq_qualify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_WIDTH(MIN_WIDTH)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (pins_s[PIN_CS]),
        .oe_s     (pins_s[PIN_OE]),
        .we_s     (pins_s[PIN_WE]),
        .wr_en    (wr_en),
        .addr_in  (addr_in),
        .data_in  (data_in),
        .acc_pulse(acc_pulse),
        .acc_addr (acc_addr),
        .acc_data (acc_data)
    );
endmodule

// File: rtl/wrq_guard_chk.sv
module wrq_guard_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              acc_pulse,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_data,
    input logic              holdoff_active
);
    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |=> !acc_pulse);

    assert_no_accept_in_holdoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |-> $past(!holdoff_active));

    assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_pulse |-> ($stable(acc_addr) && $stable(acc_data)));

    assert_supply_low_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!supply_ok, 2) && $past(!supply_ok, 3)) |-> holdoff_active);
endmodule

bind wrq_guard wrq_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .acc_pulse     (acc_pulse),
    .acc_addr      (acc_addr),
    .acc_data      (acc_data),
    .holdoff_active(holdoff_active)
);

// File: tb/wrq_guard_bench.sv
`timescale 1ns/1ps
module wrq_guard_bench;
    localparam int AW   = 16;
    localparam int DW   = 16;
    localparam int MINW = 3;
    localparam int HOLD = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_ok = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic          acc_pulse, holdoff_active;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_data;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #2.5 clk = ~clk;

    wrq_guard #(.ADDR_W(AW), .DATA_W(DW), .MIN_WIDTH(MINW), .HOLD_CYCLES(HOLD)) u_wrq_guard (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .supply_ok(supply_ok), .addr_in(addr_in), .data_in(data_in),
        .acc_pulse(acc_pulse), .acc_addr(acc_addr), .acc_data(acc_data),
        .holdoff_active(holdoff_active)
    );

    always @(negedge clk) if (rst_n && acc_pulse) pulses++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int n, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr_in = a; data_in = d; cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        repeat (n) @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic measure_hold(input string req);
        int k;
        @(negedge clk);
        supply_ok = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (holdoff_active && k < HOLD + 20);
        chk(k == HOLD + 2, req, k, HOLD + 2);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p0;
        logic [AW-1:0] a_keep;
        logic [DW-1:0] d_keep;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(acc_pulse == 1'b0, "R1 acc_pulse", acc_pulse, 0);
        chk(holdoff_active == 1'b1, "R1 holdoff_active", holdoff_active, 1);

        // R4 supply low blocks writes
        p0 = pulses;
        strobe(MINW + 3, 16'h1111, 16'h2222);
        chk(pulses == p0, "R4 accepted with supply low", pulses - p0, 0);
        chk(holdoff_active == 1'b1, "R4 holdoff_active", holdoff_active, 1);

        // R11 strobe begun in hold-off, ending after it
        p0 = pulses;
        @(negedge clk);
        supply_ok = 1'b1;
        addr_in = 16'h3333; data_in = 16'h4444; cs_n = 1'b0; we_n = 1'b0;
        repeat (HOLD + 10) @(negedge clk);
        chk(holdoff_active == 1'b0, "R11 holdoff expired", holdoff_active, 0);
        cs_n = 1'b1; we_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(pulses == p0, "R11 straddling strobe", pulses - p0, 0);

        // R5 hold-off length after supply rises
        supply_ok = 1'b0;
        repeat (5) @(negedge clk);
        p0 = pulses;
        measure_hold("R5 hold-off length");

        // R2 width sweep
        for (int n = 1; n <= MINW + 3; n++) begin
            p0 = pulses;
            strobe(n, AW'(16'h0100 + n), DW'(16'hA000 + n));
            chk((pulses - p0) == ((n >= MINW) ? 1 : 0), "R2 width sweep", pulses - p0, (n >= MINW) ? 1 : 0);
            if (n >= MINW) begin
                chk(acc_addr == AW'(16'h0100 + n), "R7 address", int'(acc_addr), 16'h0100 + n);
                chk(acc_data == DW'(16'hA000 + n), "R8 data", int'(acc_data), 16'hA000 + n);
            end
        end

        // R3 pin combination sweep
        for (int c = 0; c < 8; c++) begin
            int exp_p;
            exp_p = (c == 3'b010) ? 1 : 0;  // {cs_n,oe_n,we_n} = 0,1,0
            p0 = pulses;
            @(negedge clk);
            addr_in = AW'(16'h0200 + c); data_in = DW'(16'hB000 + c);
            cs_n = c[2]; oe_n = c[1]; we_n = c[0];
            repeat (MINW + 3) @(negedge clk);
            cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
            repeat (6) @(negedge clk);
            chk((pulses - p0) == exp_p, "R3 pin combination", pulses - p0, exp_p);
        end

        // R9 latency and single cycle
        @(negedge clk);
        addr_in = 16'h0555; data_in = 16'h0AAA; cs_n = 1'b0; we_n = 1'b0;
        repeat (MINW + 1) @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk(acc_pulse == (k == 3), "R9 pulse timing", acc_pulse, (k == 3) ? 1 : 0);
        end

        // R7 and R8: bus changes in mid-strobe
        @(negedge clk);
        addr_in = 16'h1234; data_in = 16'h0F0F; cs_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        addr_in = 16'h4321; data_in = 16'hF0F0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(acc_addr == 16'h1234, "R7 start address kept", int'(acc_addr), 16'h1234);
        chk(acc_data == 16'hF0F0, "R8 end data taken", int'(acc_data), 16'hF0F0);

        // R10 rejected strobe leaves outputs
        a_keep = acc_addr; d_keep = acc_data;
        strobe(MINW - 1, 16'h7777, 16'h8888);
        chk(acc_addr == a_keep, "R10 address held", int'(acc_addr), int'(a_keep));
        chk(acc_data == d_keep, "R10 data held", int'(acc_data), int'(d_keep));

        // R6 restart after a supply drop
        @(negedge clk);
        supply_ok = 1'b0;
        repeat (5) @(negedge clk);
        chk(holdoff_active == 1'b1, "R6 hold-off reasserted", holdoff_active, 1);
        measure_hold("R6 restarted hold-off length");
        p0 = pulses;
        strobe(MINW, 16'h0BEE, 16'h0CAF);
        chk(pulses - p0 == 1, "R6 write after restart", pulses - p0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule